// File: doc/BRIEF.md
# Burst Clock Forwarder with Selectable Park Level

This block drives an off-chip serial clock from a free-running internal clock. It is meant for a converter that must see no clock edges while it is converting. Once the conversion ends, a start request makes the block emit a fixed number of whole clock periods. The count is set at elaboration and defaults to 20. After the last period the pin parks at a level chosen by a select input.

The pin is driven by a model of a dual-edge output register. The register captures one value for the first half of each internal clock cycle (clock high) and one for the second half (clock low). One of the two inputs is held constant. The other carries a registered enable, so the enable is always synchronous to the forwarded clock. In low-park mode the enable is placed on the first-half input and the second-half input is tied to 0. In high-park mode the first-half input is tied to 1 and the second-half input carries the inverted enable. No gate sits between the last register and the pin, so a burst always starts and ends on whole periods.

Top module: `burst_clk_fwd`

## Requirements
- R1: While reset is asserted (active low, asynchronous), `sclk_o` sits at the level on `park_high_i` in both clock phases, and `busy_o` and `done_o` are 0.
- R2: With no start request, `sclk_o` stays constant at the park level in every phase (no edges).
- R3: A start request sampled at clock edge E0 produces exactly BURST_LEN (default 20) output periods, carried by the register captures at edges E1 through E(BURST_LEN).
- R4: With `park_high_i`=0, each period is high during the high phase of `clk_i` and low during its low phase, and the pin rests low after the burst.
- R5: With `park_high_i`=1, each period is low during the low phase of `clk_i` and high during its high phase, and the pin rests high after the burst.
- R6: `busy_o` goes high after the start edge and stays high for exactly BURST_LEN+1 cycles. `busy_o` and `done_o` are never high together.
- R7: `done_o` is a single-cycle pulse, high in the cycle that begins BURST_LEN+1 edges after the start edge.
- R8: A start request that arrives while `busy_o` is high is ignored. The burst length and the `done_o` timing are unchanged.
- R9: Reset during a burst stops the output at once. The pin goes to the park level, and `busy_o` goes to 0 without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running internal clock, also the source of the forwarded clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Burst request, sampled on the rising edge |
| park_high_i | input | 1 | Park level select: 0 parks low, 1 parks high |
| sclk_o | output | 1 | Forwarded clock for the pin |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle pulse after the final period |

## Verification
The assertions assume that `start_i` changes only between rising edges. They also assume that `park_high_i` is held steady for the whole of a burst, because the mode register follows it only while the block is idle. The bench changes the select only in the idle gaps between scenarios. It drives start and reset from the middle of the low phase, and it samples the pin in the middle of each phase, so every phase of a burst is observed.

// File: rtl/burst_clk_fwd_pkg.sv
package burst_clk_fwd_pkg;
   typedef enum logic {
      PARK_LOW  = 1'b0,
      PARK_HIGH = 1'b1
   } park_mode_e;

   function automatic int unsigned cnt_width(input int unsigned len);
      return (len > 2) ? $clog2(len) : 1;
   endfunction
endpackage

// File: rtl/burst_len_ctl.sv
module burst_len_ctl #(
   parameter int unsigned BURST_LEN = 20,
   localparam int unsigned CNT_W    = burst_clk_fwd_pkg::cnt_width(BURST_LEN)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   output logic             en_o,
   output logic             busy_o,
   output logic             done_o,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BURST_LEN - 1);

   logic             en_q, tail_q, done_q;
   logic [CNT_W-1:0] cnt_q;
   logic             idle;

   assign idle = ~en_q & ~tail_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q   <= 1'b0;
         tail_q <= 1'b0;
         done_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         tail_q <= en_q;
         done_q <= tail_q & ~en_q;
         if (idle && start_i) begin
            en_q  <= 1'b1;
            cnt_q <= LAST_IDX;
         end else if (en_q) begin
            if (cnt_q == '0) en_q  <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign en_o   = en_q;
   assign busy_o = ~idle;
   assign done_o = done_q;
   assign cnt_o  = cnt_q;
endmodule

// File: rtl/ddr_out_cell.sv
module ddr_out_cell (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic rst_lvl_i,
   input  logic d_first_i,
   input  logic d_second_i,
   output logic q_o
);
   logic rise_q, second_hold_q, fall_q;

   // Both data inputs are captured together on the rising edge.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rise_q        <= rst_lvl_i;
         second_hold_q <= rst_lvl_i;
      end else begin
         rise_q        <= d_first_i;
         second_hold_q <= d_second_i;
      end
   end

   // The second-half value moves to the falling-edge stage.
   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fall_q <= rst_lvl_i;
      else         fall_q <= second_hold_q;
   end

   // Phase selector inside the modelled cell; both inputs are register outputs.
   assign q_o = clk_i ? rise_q : fall_q;
endmodule

// File: rtl/burst_clk_fwd.sv
module burst_clk_fwd #(
   parameter int unsigned BURST_LEN = 20
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  logic park_high_i,
   output logic sclk_o,
   output logic busy_o,
   output logic done_o
);
   import burst_clk_fwd_pkg::*;
   localparam int unsigned CNT_W = cnt_width(BURST_LEN);

   if (BURST_LEN < 1) begin : g_len_check
      $error("burst_clk_fwd: BURST_LEN must be at least 1");
   end

   logic             en;
   logic [CNT_W-1:0] cnt;
   park_mode_e       mode_q;
   logic             d_first, d_second;

   burst_len_ctl #(.BURST_LEN(BURST_LEN)) u_ctl (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(start_i),
      .en_o   (en),
      .busy_o (busy_o),
      .done_o (done_o),
      .cnt_o  (cnt)
   );

   // Park mode follows the select only while idle.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      mode_q <= park_mode_e'(park_high_i);
      else if (!busy_o) mode_q <= park_mode_e'(park_high_i);
   end

   always_comb begin
      if (mode_q == PARK_HIGH) begin
         d_first  = 1'b1;
         d_second = ~en;
      end else begin
         d_first  = en;
         d_second = 1'b0;
      end
   end

   ddr_out_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rst_lvl_i (park_high_i),
      .d_first_i (d_first),
      .d_second_i(d_second),
      .q_o       (sclk_o)
   );
endmodule

// File: rtl/burst_clk_fwd_chk.sv
module burst_clk_fwd_chk #(
   parameter int unsigned BURST_LEN = 20,
   localparam int unsigned CNT_W    = burst_clk_fwd_pkg::cnt_width(BURST_LEN)
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             start_i,
   input logic             busy_o,
   input logic             done_o,
   input logic             en,
   input logic [CNT_W-1:0] cnt
);
   AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt <= CNT_W'(BURST_LEN - 1)) else $error("cnt out of range"); // R3

   AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o) else $error("done longer than one cycle"); // R7

   AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o) else $error("done while busy"); // R6

   AST_EN_NEEDS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(en) |-> $past(start_i)) else $error("enable without start"); // R3

   AST_NO_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en && cnt != '0) |=> (en && cnt == $past(cnt) - 1'b1))
      else $error("count reloaded mid burst"); // R8
endmodule

bind burst_clk_fwd burst_clk_fwd_chk #(.BURST_LEN(BURST_LEN)) u_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .start_i(start_i),
   .busy_o (busy_o),
   .done_o (done_o),
   .en     (en),
   .cnt    (cnt)
);

// File: tb/tb_burst_clk_fwd.sv
module tb_burst_clk_fwd;
   localparam int unsigned N = 20;

   logic clk = 1'b0;
   logic rst_ni = 1'b0;
   logic start_i = 1'b0;
   logic park_high_i = 1'b0;
   logic sclk_o, busy_o, done_o;

   int checks = 0;
   int fails  = 0;

   burst_clk_fwd #(.BURST_LEN(N)) dut (
      .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
      .park_high_i(park_high_i), .sclk_o(sclk_o),
      .busy_o(busy_o), .done_o(done_o)
   );

   always #2 clk = ~clk;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Place the bench at the middle of the next low phase.
   task automatic to_low_mid();
      @(negedge clk); #1;
   endtask

   task automatic t_reset(input logic lvl);
      rst_ni = 1'b0; park_high_i = lvl;
      @(posedge clk); #1;
      check("R1 pin high phase", sclk_o, lvl);
      check("R1 busy", busy_o, 0);
      check("R1 done", done_o, 0);
      to_low_mid();
      check("R1 pin low phase", sclk_o, lvl);
      rst_ni = 1'b1;
      repeat (2) to_low_mid();
   endtask

   task automatic t_idle(input logic lvl);
      int edges = 0;
      logic prev;
      park_high_i = lvl;
      repeat (3) to_low_mid();
      prev = sclk_o;
      for (int i = 0; i < 10; i++) begin
         @(posedge clk); #1; if (sclk_o != prev) edges++; prev = sclk_o;
         @(negedge clk); #1; if (sclk_o != prev) edges++; prev = sclk_o;
      end
      check("R2 idle edges", edges, 0);
      check("R2 idle level", sclk_o, lvl);
   endtask

   // One burst; optionally a second start while busy (R8).
   task automatic t_burst(input logic lvl, input bit retrig, input string tag);
      int hi_ones = 0, lo_ones = 0, busy_cnt = 0, done_cnt = 0, done_at = -1;
      park_high_i = lvl;
      repeat (3) to_low_mid();
      start_i = 1'b1;
      for (int i = 0; i < N + 6; i++) begin
         @(posedge clk); #1;                 // just after edge Ei
         if (sclk_o) hi_ones++;
         if (busy_o) busy_cnt++;
         if (done_o) begin done_cnt++; done_at = i; end
         @(negedge clk); #1;
         if (sclk_o) lo_ones++;
         start_i = (retrig && i == 4) ? 1'b1 : 1'b0;
      end
      if (lvl == 1'b0) begin
         check({tag, " R3/R4 periods"}, hi_ones, N);
         check({tag, " R4 low phase flat"}, lo_ones, 0);
      end else begin
         check({tag, " R3/R5 periods"}, (N + 6) - lo_ones, N);
         check({tag, " R5 high phase flat"}, hi_ones, N + 6);
      end
      check({tag, " R6 busy cycles"}, busy_cnt, N + 1);
      check({tag, " R7 done count"}, done_cnt, 1);
      check({tag, " R7 done cycle"}, done_at, N + 1);
      check({tag, " R4/R5 park level"}, sclk_o, lvl);
   endtask

   task automatic t_reset_mid(input logic lvl);
      park_high_i = lvl;
      repeat (2) to_low_mid();
      start_i = 1'b1;
      to_low_mid();
      start_i = 1'b0;
      repeat (4) to_low_mid();
      @(posedge clk); #1;                    // high phase, pulse may be showing
      rst_ni = 1'b0; #0.5;
      check("R9 pin at reset", sclk_o, lvl);
      check("R9 busy at reset", busy_o, 0);
      to_low_mid();
      check("R9 pin held", sclk_o, lvl);
      rst_ni = 1'b1;
      repeat (2) to_low_mid();
   endtask

   initial begin
      t_reset(1'b0);
      t_idle(1'b0);
      t_burst(1'b0, 1'b0, "low");
      t_reset(1'b1);
      t_idle(1'b1);
      t_burst(1'b1, 1'b0, "high");
      t_burst(1'b0, 1'b1, "low retrig R8");
      t_burst(1'b1, 1'b1, "high retrig R8");
      t_reset_mid(1'b0);
      t_reset_mid(1'b1);
      t_burst(1'b0, 1'b0, "after reset");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #400000;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule